// File: doc/BRIEF.md
# In-Bank Compare-and-Operate Engine

This block is a small compute unit placed next to the column I/O of one memory bank. Software first loads a 64-bit search operand into a key register. It then issues one range command that names an operation, a start word address and an item count. The engine turns that single command into a local series of column reads, plus write-backs for the increment operation. It compares every fetched bank word against the key, or against the best word found so far. It returns compare outcomes, one extreme value, or nothing at all when it updates the bank in place. Raw bank data never leaves the block.

Four operations exist. Scan packs a three-way outcome for every item into 64-bit result words. Minimum and maximum return the extreme word of the range. Increment walks key/value word pairs and adds one to the value of every pair whose key matches. Comparisons are unsigned unless the command asks for signed. A narrow flag restricts both operands to their low 32 bits. Results leave through an 8-entry queue with a valid/ready read port. A result word is held stable while `res_valid` is high and `res_ready` is low, and a word is removed only on a cycle where both are high. While the queue is full, the sequencer pauses and no outcome is lost.

Top module: `bank_cmp_engine`

## Requirements
- R1: `key_we` loads `key_data` into the key register at the clock edge, unless `busy` is high, in which case the write is ignored. Every later command compares against the stored key.
- R2: A command is taken at an edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` equals `!busy`. `busy` rises at acceptance and falls after the final result is enqueued, or after the last write-back. A command offered while busy is dropped and has no effect. No bank access happens while idle.
- R3: With scan (`cmd_op`=0), item k of the range, taken from word `cmd_addr`+k, produces a 2-bit code of 00 for equal, 01 when the item is below the key, and 10 when it is above. Codes for items 32j..32j+31 fill result word j, with item 32j+i at bits [2i+1:2i]. After the last item, a partly filled word is pushed with its unused bits at zero.
- R4: `cmd_signed`=0 compares as unsigned and `cmd_signed`=1 compares as two's complement, for both scan and selection.
- R5: `cmd_narrow`=1 compares only bits [31:0] of both operands, sign-extended from bit 31 when signed. In this mode a selected result is returned as its low 32 bits, zero-extended.
- R6: `cmd_op`=1 (minimum) or 2 (maximum) pushes exactly one result word, the least or greatest item of the range.
- R7: With `cmd_op`=3, pair p has its key at word `cmd_addr`+2p and its value at word `cmd_addr`+2p+1, and `cmd_count` is the number of pairs. When the key matches, the value word is read, and in the next cycle value+1 is written to the same address. In narrow mode only bits [31:0] are incremented, wrapping, and bits [63:32] are kept. Words of pairs that do not match are not written. No result is pushed.
- R8: The result queue holds 8 words and delivers them in order. `res_valid` is high and `res_empty` is low whenever a word is held. When the queue is full, the sequencer stalls until a word is drained, and the run completes with every result intact.
- R9: `bank_rdata` is taken one cycle after `bank_rd_en` and must hold until the next read. Each item takes two cycles, so `busy` stays high for 2N cycles for a scan of N items, 2N+1 for a selection, and 2 per pair plus 2 per match for an increment, when the queue does not stall.
- R10: A command with `cmd_count`=0 keeps `busy` high for one cycle, pushes nothing and touches no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_we | input | 1 | Load the key register |
| key_data | input | 64 | Key value to load |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 2 | 0 scan, 1 minimum, 2 maximum, 3 increment |
| cmd_signed | input | 1 | Signed comparison |
| cmd_narrow | input | 1 | 32-bit operand mode |
| cmd_addr | input | 10 | First word address of the range |
| cmd_count | input | 10 | Item count (pairs for increment) |
| bank_rd_en | output | 1 | Column read strobe |
| bank_wr_en | output | 1 | Column write strobe |
| bank_addr | output | 10 | Column word address |
| bank_wdata | output | 64 | Write-back data |
| bank_rdata | input | 64 | Read data, valid the cycle after a read |
| busy | output | 1 | Command in progress |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer takes the result word |
| res_data | output | 64 | Head result word |
| res_empty | output | 1 | Result queue empty |

## Verification
Each result has a fixed due cycle counted from the acceptance edge. A scan's last word is enqueued 2N edges later, a selection word 2N+1 edges later, and an increment's writes finish after 2 cycles per pair plus 2 per match. The bench drives inputs and samples outputs on the falling edge and counts rising edges from acceptance until `busy` drops. It compares that count with these figures before it drains and checks the queue. The full-queue case deliberately breaks this timing: the bench leaves a nine-word scan undrained well past its nominal length, checks that the engine is still busy, and then drains and checks every word in order.

// File: rtl/bce_pkg.sv
`timescale 1ns/1ps
package bce_pkg;
  typedef enum logic [1:0] {
    OP_SCAN = 2'd0,
    OP_MIN  = 2'd1,
    OP_MAX  = 2'd2,
    OP_INC  = 2'd3
  } bce_op_e;

  localparam logic [1:0] OUT_EQ = 2'b00;
  localparam logic [1:0] OUT_LT = 2'b01;
  localparam logic [1:0] OUT_GT = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_EVAL,
    ST_VRD,
    ST_WB,
    ST_FIN
  } bce_state_e;
endpackage

// File: rtl/bce_compare.sv
`timescale 1ns/1ps
module bce_compare #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] item_i,
  input  logic [DW-1:0] ref_i,
  input  logic          sgn_i,
  input  logic          narrow_i,
  output logic [1:0]    outcome_o
);
  import bce_pkg::*;
  localparam int HW = DW / 2;

  logic [DW-1:0] ea, eb;
  logic          lt;

  always_comb begin
    if (narrow_i) begin
      ea = {{HW{sgn_i & item_i[HW-1]}}, item_i[HW-1:0]};
      eb = {{HW{sgn_i & ref_i[HW-1]}},  ref_i[HW-1:0]};
    end else begin
      ea = item_i;
      eb = ref_i;
    end
    lt = sgn_i ? ($signed(ea) < $signed(eb)) : (ea < eb);
    if (ea == eb)  outcome_o = OUT_EQ;
    else if (lt)   outcome_o = OUT_LT;
    else           outcome_o = OUT_GT;
  end
endmodule

// File: rtl/bce_result_fifo.sv
`timescale 1ns/1ps
module bce_result_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  logic [DW-1:0]            push_data_i,
  input  logic                     pop_i,
  output logic [DW-1:0]            rd_data_o,
  output logic                     empty_o,
  output logic                     full_o,
  output logic [$clog2(DEPTH):0]   count_o
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] store_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [PW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == (PW+1)'(DEPTH));
  assign count_o   = cnt_q;
  assign rd_data_o = store_q[rd_q];
  assign do_push   = push_i && !full_o;
  assign do_pop    = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (do_push) store_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + PW'(1);
      if (do_pop)  rd_q <= rd_q + PW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + (PW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (PW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/bce_sequencer.sv
`timescale 1ns/1ps
module bce_sequencer #(
  parameter int DW = 64,
  parameter int AW = 10,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_fire_i,
  input  logic [1:0]    cmd_op_i,
  input  logic          cmd_signed_i,
  input  logic          cmd_narrow_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [CW-1:0] cmd_count_i,
  input  logic [DW-1:0] key_i,
  input  logic [DW-1:0] bank_rdata_i,
  input  logic          q_full_i,
  output logic          bank_rd_en_o,
  output logic          bank_wr_en_o,
  output logic [AW-1:0] bank_addr_o,
  output logic [DW-1:0] bank_wdata_o,
  output logic          push_o,
  output logic [DW-1:0] push_data_o,
  output logic          busy_o
);
  import bce_pkg::*;
  localparam int HW     = DW / 2;
  localparam int SLOTS  = DW / 2;
  localparam int SLOT_W = $clog2(SLOTS);

  bce_state_e        state_q;
  bce_op_e           op_q;
  logic              sgn_q, nar_q;
  logic [AW-1:0]     addr_q;
  logic [CW-1:0]     left_q;
  logic [SLOT_W-1:0] slot_q;
  logic [DW-1:0]     acc_q, best_q;
  logic              have_best_q;

  logic [1:0]        oc_key, oc_best;
  logic              last, word_done, is_sel, take;
  logic [SLOT_W:0]   shamt;
  logic [DW-1:0]     acc_next, item_sel;
  logic [AW-1:0]     step;

  bce_compare #(.DW(DW)) u_cmp_key (
    .item_i(bank_rdata_i), .ref_i(key_i), .sgn_i(sgn_q), .narrow_i(nar_q),
    .outcome_o(oc_key)
  );

  bce_compare #(.DW(DW)) u_cmp_best (
    .item_i(bank_rdata_i), .ref_i(best_q), .sgn_i(sgn_q), .narrow_i(nar_q),
    .outcome_o(oc_best)
  );

  always_comb begin
    last      = (left_q == CW'(1));
    word_done = (slot_q == SLOT_W'(SLOTS - 1)) || last;
    is_sel    = (op_q == OP_MIN) || (op_q == OP_MAX);
    shamt     = {slot_q, 1'b0};
    acc_next  = acc_q | ({{(DW-2){1'b0}}, oc_key} << shamt);
    item_sel  = nar_q ? {{HW{1'b0}}, bank_rdata_i[HW-1:0]} : bank_rdata_i;
    take      = !have_best_q ||
                ((op_q == OP_MIN) ? (oc_best == OUT_LT) : (oc_best == OUT_GT));
    step      = (op_q == OP_INC) ? AW'(2) : AW'(1);

    bank_rd_en_o = ((state_q == ST_RD) && (left_q != '0)) || (state_q == ST_VRD);
    bank_wr_en_o = (state_q == ST_WB);
    bank_addr_o  = ((state_q == ST_VRD) || (state_q == ST_WB)) ? addr_q + AW'(1) : addr_q;
    bank_wdata_o = nar_q ? {bank_rdata_i[DW-1:HW], bank_rdata_i[HW-1:0] + HW'(1)}
                         : bank_rdata_i + DW'(1);

    push_o      = ((state_q == ST_EVAL) && (op_q == OP_SCAN) && word_done && !q_full_i) ||
                  ((state_q == ST_FIN) && !q_full_i);
    push_data_o = (state_q == ST_FIN) ? best_q : acc_next;
    busy_o      = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_SCAN;
      sgn_q       <= 1'b0;
      nar_q       <= 1'b0;
      addr_q      <= '0;
      left_q      <= '0;
      slot_q      <= '0;
      acc_q       <= '0;
      best_q      <= '0;
      have_best_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_fire_i) begin
            op_q        <= bce_op_e'(cmd_op_i);
            sgn_q       <= cmd_signed_i;
            nar_q       <= cmd_narrow_i;
            addr_q      <= cmd_addr_i;
            left_q      <= cmd_count_i;
            slot_q      <= '0;
            acc_q       <= '0;
            have_best_q <= 1'b0;
            state_q     <= ST_RD;
          end
        end
        ST_RD: begin
          state_q <= (left_q == '0) ? ST_IDLE : ST_EVAL;
        end
        ST_EVAL: begin
          if ((op_q == OP_SCAN) && word_done && q_full_i) begin
            state_q <= ST_EVAL;
          end else if ((op_q == OP_INC) && (oc_key == OUT_EQ)) begin
            state_q <= ST_VRD;
          end else begin
            if (op_q == OP_SCAN) begin
              acc_q  <= word_done ? '0 : acc_next;
              slot_q <= word_done ? '0 : slot_q + SLOT_W'(1);
            end
            if (is_sel && take) begin
              best_q      <= item_sel;
              have_best_q <= 1'b1;
            end
            left_q  <= left_q - CW'(1);
            addr_q  <= addr_q + step;
            state_q <= last ? (is_sel ? ST_FIN : ST_IDLE) : ST_RD;
          end
        end
        ST_VRD: begin
          state_q <= ST_WB;
        end
        ST_WB: begin
          left_q  <= left_q - CW'(1);
          addr_q  <= addr_q + AW'(2);
          state_q <= last ? ST_IDLE : ST_RD;
        end
        ST_FIN: begin
          if (!q_full_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bank_cmp_engine.sv
`timescale 1ns/1ps
module bank_cmp_engine #(
  parameter int DW     = 64,
  parameter int AW     = 10,
  parameter int CW     = 10,
  parameter int QDEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [DW-1:0] key_data,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_signed,
  input  logic          cmd_narrow,
  input  logic [AW-1:0] cmd_addr,
  input  logic [CW-1:0] cmd_count,
  output logic          bank_rd_en,
  output logic          bank_wr_en,
  output logic [AW-1:0] bank_addr,
  output logic [DW-1:0] bank_wdata,
  input  logic [DW-1:0] bank_rdata,
  output logic          busy,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          res_empty
);
  localparam int QCW = $clog2(QDEPTH) + 1;

  logic [DW-1:0]  key_q;
  logic           cmd_fire, q_push, q_full;
  logic [DW-1:0]  q_push_data;
  logic [QCW-1:0] fifo_count;

  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign res_valid = !res_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)                key_q <= '0;
    else if (key_we && !busy)  key_q <= key_data;
  end

  bce_sequencer #(.DW(DW), .AW(AW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_fire_i(cmd_fire), .cmd_op_i(cmd_op),
    .cmd_signed_i(cmd_signed), .cmd_narrow_i(cmd_narrow), .cmd_addr_i(cmd_addr),
    .cmd_count_i(cmd_count), .key_i(key_q), .bank_rdata_i(bank_rdata),
    .q_full_i(q_full), .bank_rd_en_o(bank_rd_en), .bank_wr_en_o(bank_wr_en),
    .bank_addr_o(bank_addr), .bank_wdata_o(bank_wdata), .push_o(q_push),
    .push_data_o(q_push_data), .busy_o(busy)
  );

  bce_result_fifo #(.DW(DW), .DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(q_push), .push_data_i(q_push_data),
    .pop_i(res_valid && res_ready), .rd_data_o(res_data), .empty_o(res_empty),
    .full_o(q_full), .count_o(fifo_count)
  );
endmodule

// File: rtl/bce_checker.sv
`timescale 1ns/1ps
module bce_checker #(
  parameter int DW     = 64,
  parameter int AW     = 10,
  parameter int QDEPTH = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      busy,
  input logic                      cmd_valid,
  input logic                      bank_rd_en,
  input logic                      bank_wr_en,
  input logic [AW-1:0]             bank_addr,
  input logic                      res_valid,
  input logic                      res_ready,
  input logic [DW-1:0]             res_data,
  input logic [$clog2(QDEPTH):0]   fifo_count
);
  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bank_rd_en && !bank_wr_en));

  // R7
  wb_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_en |-> ($past(bank_rd_en) && (bank_addr == $past(bank_addr))));

  // R9
  read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rd_en |=> !bank_rd_en);

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(QDEPTH)+1)'(QDEPTH));
endmodule

bind bank_cmp_engine bce_checker #(.DW(DW), .AW(AW), .QDEPTH(QDEPTH)) u_bce_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_valid(cmd_valid),
  .bank_rd_en(bank_rd_en), .bank_wr_en(bank_wr_en), .bank_addr(bank_addr),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .fifo_count(fifo_count)
);

// File: tb/bank_cmp_engine_test.sv
`timescale 1ns/1ps
module bank_cmp_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_we = 1'b0;
  logic [63:0] key_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_signed = 1'b0;
  logic        cmd_narrow = 1'b0;
  logic [9:0]  cmd_addr = '0;
  logic [9:0]  cmd_count = '0;
  logic        bank_rd_en, bank_wr_en;
  logic [9:0]  bank_addr;
  logic [63:0] bank_wdata;
  logic [63:0] bank_rdata = '0;
  logic        busy, res_valid, res_empty;
  logic        res_ready = 1'b0;
  logic [63:0] res_data;

  logic [63:0] mem [1024];
  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] cur_key = '0;

  always #10 clk = ~clk;

  bank_cmp_engine uut (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_signed(cmd_signed), .cmd_narrow(cmd_narrow), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .bank_rd_en(bank_rd_en), .bank_wr_en(bank_wr_en),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
    .busy(busy), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_empty(res_empty)
  );

  always @(posedge clk) begin
    if (bank_rd_en) bank_rdata <= mem[bank_addr];
    if (bank_wr_en) mem[bank_addr] <= bank_wdata;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_cmp(logic [63:0] it, logic [63:0] k, bit sgn, bit nar);
    logic signed [64:0] a, b;
    if (nar) begin
      a = sgn ? {{33{it[31]}}, it[31:0]} : {33'd0, it[31:0]};
      b = sgn ? {{33{k[31]}},  k[31:0]}  : {33'd0, k[31:0]};
    end else begin
      a = sgn ? {it[63], it} : {1'b0, it};
      b = sgn ? {k[63], k}   : {1'b0, k};
    end
    if (a == b) return 2'b00;
    return (a < b) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [63:0] ref_pack(int base, int n, bit sgn, bit nar);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[2*i +: 2] = ref_cmp(mem[base+i], cur_key, sgn, nar);
    return r;
  endfunction

  function automatic logic [63:0] ref_sel(int base, int n, bit is_max, bit sgn, bit nar);
    logic [63:0] best = mem[base];
    for (int i = 1; i < n; i++) begin
      logic [1:0] c = ref_cmp(mem[base+i], best, sgn, nar);
      if (is_max ? (c == 2'b10) : (c == 2'b01)) best = mem[base+i];
    end
    return nar ? {32'd0, best[31:0]} : best;
  endfunction

  task automatic load_key(input logic [63:0] k);
    @(negedge clk);
    key_we = 1'b1; key_data = k;
    @(negedge clk);
    key_we = 1'b0;
    cur_key = k;
  endtask

  task automatic run_cmd(input logic [1:0] op, input bit sgn, input bit nar,
                         input int addr, input int cnt, output int cyc);
    @(negedge clk);
    chk("R2 ready before command", cmd_ready, 1'b1);
    cmd_valid = 1'b1; cmd_op = op; cmd_signed = sgn; cmd_narrow = nar;
    cmd_addr = 10'(addr); cmd_count = 10'(cnt);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (busy) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic pop_chk(input string req, input logic [63:0] exp);
    @(negedge clk);
    chk({req, " valid"}, res_valid, 1'b1);
    chk(req, res_data, exp);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 busy after reset", busy, 1'b0);
    chk("R2 ready after reset", cmd_ready, 1'b1);
    chk("R8 valid after reset", res_valid, 1'b0);
    chk("R8 empty after reset", res_empty, 1'b1);
  endtask

  task automatic t_scan_small;
    int cyc;
    mem[16] = 64'd100; mem[17] = 64'd50; mem[18] = 64'd200; mem[19] = 64'd100;
    mem[20] = 64'hffff_ffff_ffff_fff0;
    load_key(64'd100);
    run_cmd(2'd0, 1'b0, 1'b0, 16, 5, cyc);
    chk("R9 scan busy cycles", 64'(cyc), 64'd10);
    pop_chk("R3 unsigned scan word", ref_pack(16, 5, 1'b0, 1'b0));
    chk("R8 empty after drain", res_empty, 1'b1);
    run_cmd(2'd0, 1'b1, 1'b0, 16, 5, cyc);
    pop_chk("R4 signed scan word", ref_pack(16, 5, 1'b1, 1'b0));
    chk("R4 signed code of negative item", 64'(ref_pack(16, 5, 1'b1, 1'b0) >> 8), 64'h1);
  endtask

  task automatic t_scan_long;
    int cyc;
    for (int i = 0; i < 40; i++) mem[64+i] = 64'(i * 3);
    load_key(64'd60);
    run_cmd(2'd0, 1'b0, 1'b0, 64, 40, cyc);
    chk("R9 long scan busy cycles", 64'(cyc), 64'd80);
    pop_chk("R3 full word of 32 outcomes", ref_pack(64, 32, 1'b0, 1'b0));
    pop_chk("R3 partial word zero filled", ref_pack(96, 8, 1'b0, 1'b0));
  endtask

  task automatic t_narrow;
    int cyc;
    mem[120] = {32'hdead_beef, 32'd7};
    mem[121] = {32'h0000_0001, 32'hffff_ffff};
    mem[122] = {32'h0000_0000, 32'd9};
    load_key({32'h0, 32'd7});
    run_cmd(2'd0, 1'b0, 1'b1, 120, 3, cyc);
    pop_chk("R5 narrow unsigned scan", 64'b10_10_00);
    run_cmd(2'd0, 1'b1, 1'b1, 120, 3, cyc);
    pop_chk("R5 narrow signed scan", 64'b10_01_00);
  endtask

  task automatic t_select;
    int cyc;
    mem[140] = 64'd5; mem[141] = 64'hffff_ffff_ffff_fffe; mem[142] = 64'd900;
    mem[143] = 64'd3; mem[144] = 64'd900;
    run_cmd(2'd2, 1'b0, 1'b0, 140, 5, cyc);
    chk("R9 select busy cycles", 64'(cyc), 64'd11);
    pop_chk("R6 unsigned max", 64'hffff_ffff_ffff_fffe);
    run_cmd(2'd1, 1'b1, 1'b0, 140, 5, cyc);
    pop_chk("R4 signed min", 64'hffff_ffff_ffff_fffe);
    run_cmd(2'd1, 1'b0, 1'b0, 140, 5, cyc);
    pop_chk("R6 unsigned min", 64'd3);
    run_cmd(2'd2, 1'b1, 1'b0, 140, 5, cyc);
    pop_chk("R6 signed max", 64'd900);
    mem[150] = {32'hffff_0000, 32'd4}; mem[151] = {32'h0, 32'd12}; mem[152] = {32'h7fff_ffff, 32'd2};
    run_cmd(2'd2, 1'b0, 1'b1, 150, 3, cyc);
    pop_chk("R5 narrow max zero extended", ref_sel(150, 3, 1'b1, 1'b0, 1'b1));
    chk("R5 narrow max value", ref_sel(150, 3, 1'b1, 1'b0, 1'b1), 64'd12);
  endtask

  task automatic t_increment;
    int cyc;
    mem[200] = 64'd5; mem[201] = 64'd10;
    mem[202] = 64'd7; mem[203] = 64'd20;
    mem[204] = 64'd5; mem[205] = 64'd30;
    mem[206] = 64'd9; mem[207] = {32'h1234_5678, 32'hffff_ffff};
    load_key(64'd5);
    run_cmd(2'd3, 1'b0, 1'b0, 200, 4, cyc);
    chk("R9 increment busy cycles", 64'(cyc), 64'd12);
    chk("R7 first match incremented", mem[201], 64'd11);
    chk("R7 unmatched value kept", mem[203], 64'd20);
    chk("R7 second match incremented", mem[205], 64'd31);
    chk("R7 key word kept", mem[200], 64'd5);
    chk("R7 nothing enqueued", res_empty, 1'b1);
    load_key({32'hffff_ffff, 32'd9});
    run_cmd(2'd3, 1'b0, 1'b1, 200, 4, cyc);
    chk("R7 narrow wrap keeps upper half", mem[207], {32'h1234_5678, 32'h0});
    chk("R5 narrow increment skips others", mem[205], 64'd31);
  endtask

  task automatic t_reject;
    int cyc;
    mem[300] = 64'd1; mem[301] = 64'd2; mem[302] = 64'd3; mem[303] = 64'd4;
    load_key(64'd2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_signed = 1'b0; cmd_narrow = 1'b0;
    cmd_addr = 10'd300; cmd_count = 10'd4;
    @(posedge clk);
    @(negedge clk);
    chk("R2 ready low while busy", cmd_ready, 1'b0);
    cmd_op = 2'd3; cmd_addr = 10'd301; cmd_count = 10'd1;
    key_we = 1'b1; key_data = 64'd3;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; key_we = 1'b0;
    while (busy) begin
      @(posedge clk);
      @(negedge clk);
    end
    pop_chk("R2 only first command result", ref_pack(300, 4, 1'b0, 1'b0));
    chk("R2 dropped command wrote nothing", mem[302], 64'd3);
    chk("R2 no extra result", res_empty, 1'b1);
    run_cmd(2'd0, 1'b0, 1'b0, 300, 4, cyc);
    pop_chk("R1 key write while busy ignored", ref_pack(300, 4, 1'b0, 1'b0));
  endtask

  task automatic t_zero;
    int cyc;
    mem[400] = 64'd77;
    run_cmd(2'd3, 1'b0, 1'b0, 400, 0, cyc);
    chk("R10 zero count busy cycles", 64'(cyc), 64'd1);
    chk("R10 zero count no result", res_empty, 1'b1);
    chk("R10 zero count no write", mem[400], 64'd77);
    run_cmd(2'd2, 1'b0, 1'b0, 400, 0, cyc);
    chk("R10 zero count select no result", res_empty, 1'b1);
  endtask

  task automatic t_full;
    for (int i = 0; i < 288; i++) mem[500+i] = 64'((i * 37) % 101);
    load_key(64'd50);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_signed = 1'b0; cmd_narrow = 1'b0;
    cmd_addr = 10'd500; cmd_count = 10'd288;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (800) @(posedge clk);
    @(negedge clk);
    chk("R8 stalled while queue full", busy, 1'b1);
    chk("R8 queue not empty", res_empty, 1'b0);
    for (int w = 0; w < 9; w++) pop_chk("R8 word after stall", ref_pack(500 + 32*w, 32, 1'b0, 1'b0));
    chk("R8 run completed", busy, 1'b0);
    chk("R8 empty at end", res_empty, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_scan_small();
    t_scan_long();
    t_narrow();
    t_select();
    t_increment();
    t_reject();
    t_zero();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule